// File: doc/BRIEF.md
# Precise Trust-Label Shadow Logic with Toggle Counter

This block pairs every data bit with a one-bit trust label, where a label of 1 marks the bit as tainted (untrusted) and 0 marks it as trusted. It provides shadow cells for inversion, two-input AND, two-input OR (built from AND with inverted pins), a 2:1 multiplexer and a register. Each cell computes its output label precisely. An output is tainted only when some tainted input could change its value, given the present values of the trusted inputs. A trusted controlling value therefore removes taint instead of passing it on, and so does a trusted clear.

The cells are wired into a small demonstration circuit: a one-bit counter state `q`. The next state is `((q xor en) and not clr) or set`. The enable, clear and set inputs each carry their own label, and the state register stores its label on the same edge as its value. A sticky flag watches for taint from one designated secret input reaching the counter state. A parameter picks the secret input; the default is the enable input.

Top module: `taint_counter_top`

## Requirements
- R1: A synchronous active-high `rst` sampled at a rising edge gives `q`=0, `q_t`=0 and `leak`=0 after that edge.
- R2: With `rst` low, each rising edge loads `q` with `((q ^ en) & ~clr) | set`, computed from the values present before the edge.
- R3: At the same edge, `q_t` becomes 1 exactly when some assignment of values to the currently tainted inputs changes the next `q` value. The tainted inputs are the present state when `q_t`=1, and any of `en`, `clr`, `set` whose label is 1. The other inputs stay at their present values.
- R4: A trusted clear (`clr`=1, `clr_t`=0) with a trusted `set`=0 yields `q_t`=0 after the edge, whatever the prior state label or the enable label.
- R5: A trusted `set`=1 yields `q`=1 and `q_t`=0 after the edge, whatever the other inputs and labels.
- R6: When the state and all three input labels are trusted, the state stays trusted after the edge.
- R7: With the default secret selection (the enable input), `leak` becomes 1 at an edge where `q_t` goes from 0 to 1 while `en_t`=1, `clr_t`=0 and `set_t`=0.
- R8: Once set, `leak` stays 1 until `rst`.
- R9: Taint that reaches the state while a non-secret input label is 1 does not set `leak`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Toggle enable value |
| en_t | input | 1 | Label of `en` (1 = tainted) |
| clr | input | 1 | Counter clear value |
| clr_t | input | 1 | Label of `clr` |
| set | input | 1 | Counter set value (dominates clear) |
| set_t | input | 1 | Label of `set` |
| q | output | 1 | Counter state value |
| q_t | output | 1 | Counter state label |
| leak | output | 1 | Sticky flag: secret taint reached the state |

## Verification
The state value, the state label and the leak flag all change at the first rising edge after their inputs are applied. None of them has a combinational path from input to output. The bench drives each input vector just after a falling edge and lets one rising edge pass. It compares all three outputs at the next falling edge against a model updated once per vector. The expected label comes from enumerating every value of the tainted inputs, not from the cell equations.

// File: rtl/taint_pkg.sv
package taint_pkg;

    localparam logic TRUSTED = 1'b0;
    localparam logic TAINTED = 1'b1;

    // one data bit with its trust label
    typedef struct packed {
        logic v;
        logic t;
    } tbit_t;

    // which labelled input of the counter counts as the secret
    typedef enum logic [1:0] {
        SRC_EN  = 2'd0,
        SRC_CLR = 2'd1,
        SRC_SET = 2'd2
    } src_e;

    localparam int NUM_SRC = 3;

    // inversion never changes who controls the bit
    function automatic tbit_t t_not(input tbit_t a);
        tbit_t r;
        r.v = ~a.v;
        r.t = a.t;
        return r;
    endfunction

    // AND: a trusted 0 on either side decides the output
    function automatic logic and_label(input tbit_t a, input tbit_t b);
        return (a.v & b.t) | (b.v & a.t) | (a.t & b.t);
    endfunction

    // mux: a tainted select matters only when the data inputs differ
    function automatic logic mux_label(input tbit_t s, input tbit_t a, input tbit_t b);
        return (~s.v & a.t) | (s.v & b.t) | (s.t & (a.v ^ b.v))
             | (s.t & a.t) | (s.t & b.t);
    endfunction

endpackage

// File: rtl/taint_and2.sv
module taint_and2
    import taint_pkg::*;
#(
    parameter bit INV_A = 1'b0,
    parameter bit INV_B = 1'b0,
    parameter bit INV_Y = 1'b0
) (
    input  tbit_t a,
    input  tbit_t b,
    output tbit_t y
);

    tbit_t ai, bi, core;

    generate
        if (INV_A) begin : g_ia
            assign ai = t_not(a);
        end else begin : g_pa
            assign ai = a;
        end
        if (INV_B) begin : g_ib
            assign bi = t_not(b);
        end else begin : g_pb
            assign bi = b;
        end
    endgenerate

    assign core.v = ai.v & bi.v;
    assign core.t = and_label(ai, bi);

    generate
        if (INV_Y) begin : g_iy
            assign y = t_not(core);
        end else begin : g_py
            assign y = core;
        end
    endgenerate

endmodule

// File: rtl/taint_mux2.sv
module taint_mux2
    import taint_pkg::*;
(
    input  tbit_t sel,
    input  tbit_t a,
    input  tbit_t b,
    output tbit_t y
);

    assign y.v = sel.v ? b.v : a.v;
    assign y.t = mux_label(sel, a, b);

endmodule

// File: rtl/taint_dff.sv
module taint_dff #(
    parameter int              WIDTH = 1,
    parameter logic [WIDTH-1:0] RST_V = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_v,
    input  logic [WIDTH-1:0] d_t,
    output logic [WIDTH-1:0] q_v,
    output logic [WIDTH-1:0] q_t
);

    // value and label share one edge; reset yields trusted labels
    always_ff @(posedge clk) begin
        if (rst) begin
            q_v <= RST_V;
            q_t <= '0;
        end else begin
            q_v <= d_v;
            q_t <= d_t;
        end
    end

endmodule

// File: rtl/taint_counter_top.sv
module taint_counter_top
    import taint_pkg::*;
#(
    parameter src_e SECRET = SRC_EN
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic en_t,
    input  logic clr,
    input  logic clr_t,
    input  logic set,
    input  logic set_t,
    output logic q,
    output logic q_t,
    output logic leak
);

    localparam logic [NUM_SRC-1:0] SECRET_MASK = NUM_SRC'(1) << SECRET;

    tbit_t en_s, clr_s, set_s, st_s, st_n, tog_s, kept_s, nxt_s;
    logic  st_v, st_t;
    logic  leak_r;
    logic [NUM_SRC-1:0] src_lbl;
    logic  only_secret;

    assign en_s  = '{v: en,  t: en_t};
    assign clr_s = '{v: clr, t: clr_t};
    assign set_s = '{v: set, t: set_t};
    assign st_s  = '{v: st_v, t: st_t};
    assign st_n  = t_not(st_s);

    // toggle when enabled
    taint_mux2 u_tog (
        .sel (en_s),
        .a   (st_s),
        .b   (st_n),
        .y   (tog_s)
    );

    // clear: AND with inverted clear
    taint_and2 #(.INV_A(1'b0), .INV_B(1'b1), .INV_Y(1'b0)) u_clr (
        .a (tog_s),
        .b (clr_s),
        .y (kept_s)
    );

    // set: OR formed as inverted AND of inverted pins
    taint_and2 #(.INV_A(1'b1), .INV_B(1'b1), .INV_Y(1'b1)) u_set (
        .a (kept_s),
        .b (set_s),
        .y (nxt_s)
    );

    taint_dff #(.WIDTH(1), .RST_V(1'b0)) u_state (
        .clk (clk),
        .rst (rst),
        .d_v (nxt_s.v),
        .d_t (nxt_s.t),
        .q_v (st_v),
        .q_t (st_t)
    );

    // bit order follows src_e encoding
    assign src_lbl     = {set_t, clr_t, en_t};
    assign only_secret = (src_lbl == SECRET_MASK);

    always_ff @(posedge clk) begin
        if (rst) begin
            leak_r <= 1'b0;
        end else if (!st_t && only_secret && nxt_s.t) begin
            leak_r <= 1'b1;
        end
    end

    assign q    = st_v;
    assign q_t  = st_t;
    assign leak = leak_r;

endmodule

// File: rtl/taint_counter_chk.sv
module taint_counter_chk (
    input logic clk,
    input logic rst,
    input logic en,
    input logic en_t,
    input logic clr,
    input logic clr_t,
    input logic set,
    input logic set_t,
    input logic q,
    input logic q_t,
    input logic leak
);

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!q && !q_t && !leak));

    // R2
    toggle_value_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && !set) |=> (q == ($past(q) ^ $past(en))));

    // R4
    trusted_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr && !clr_t && !set && !set_t) |=> !q_t);

    // R5
    trusted_set_chk: assert property (@(posedge clk) disable iff (rst)
        (set && !set_t) |=> (q && !q_t));

    // R6
    stays_trusted_chk: assert property (@(posedge clk) disable iff (rst)
        (!q_t && !en_t && !clr_t && !set_t) |=> !q_t);

    // R7
    leak_with_taint_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(leak) |-> $rose(q_t));

    // R8
    leak_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        leak |=> leak);

endmodule

bind taint_counter_top taint_counter_chk chk_i (.*);

// File: tb/taint_counter_top_tb_top.sv
module taint_counter_top_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 0, en_t = 0, clr = 0, clr_t = 0, set = 0, set_t = 0;
    logic q, q_t, leak;

    int n_chk = 0;
    int n_bad = 0;

    bit m_q, m_t, m_l;

    always #5 clk = ~clk;

    taint_counter_top dut_i (
        .clk(clk), .rst(rst),
        .en(en), .en_t(en_t), .clr(clr), .clr_t(clr_t),
        .set(set), .set_t(set_t),
        .q(q), .q_t(q_t), .leak(leak)
    );

    function automatic bit f_val(bit sq, bit se, bit sc, bit ss);
        return ((sq ^ se) & ~sc) | ss;
    endfunction

    // label by enumeration over the tainted inputs
    function automatic bit f_lbl(bit sq, bit tq, bit se, bit te,
                                 bit sc, bit tc, bit ss, bit ts);
        bit first = 0, seen = 0, dif = 0;
        for (int k = 0; k < 16; k++) begin
            bit vq = tq ? k[0] : sq;
            bit ve = te ? k[1] : se;
            bit vc = tc ? k[2] : sc;
            bit vs = ts ? k[3] : ss;
            bit r  = f_val(vq, ve, vc, vs);
            if (!seen) begin first = r; seen = 1; end
            else if (r != first) dif = 1;
        end
        return dif;
    endfunction

    task automatic check(input logic got, input bit exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_q = 0; m_t = 0; m_l = 0;
        check(q, 0, "R1 q");
        check(q_t, 0, "R1 q_t");
        check(leak, 0, "R1 leak");
    endtask

    task automatic step(input bit ie, input bit iet, input bit ic, input bit ict,
                        input bit is, input bit ist,
                        input string tq, input string tt, input string tl);
        bit nq, nt;
        en = ie; en_t = iet; clr = ic; clr_t = ict; set = is; set_t = ist;
        nq = f_val(m_q, ie, ic, is);
        nt = f_lbl(m_q, m_t, ie, iet, ic, ict, is, ist);
        // secret is the enable input by default
        m_l = m_l | (!m_t && iet && !ict && !ist && nt);
        m_q = nq; m_t = nt;
        @(negedge clk);
        check(q, m_q, tq);
        check(q_t, m_t, tt);
        check(leak, m_l, tl);
    endtask

    initial begin
        #(100000 * 10);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_7a17));
        do_reset();
        // R6: all trusted, toggle a few times
        step(1,0, 0,0, 0,0, "R2 toggle", "R6 trusted", "R9 leak");
        step(1,0, 0,0, 0,0, "R2 toggle", "R6 trusted", "R9 leak");
        step(0,0, 0,0, 0,0, "R2 hold", "R6 trusted", "R9 leak");
        // R7: tainted enable alone taints the state
        step(1,1, 0,0, 0,0, "R2 toggle", "R3 enable taint", "R7 leak set");
        // R4 with R8: trusted clear wipes taint, leak holds
        step(1,1, 1,0, 0,0, "R2 clear", "R4 clear", "R8 leak hold");
        step(0,0, 0,0, 0,0, "R2 hold", "R6 trusted", "R8 leak hold");
        do_reset();
        // R9: tainted clear taints state, not the secret
        step(1,0, 0,1, 0,0, "R2 value", "R3 clear taint", "R9 no leak");
        step(1,1, 0,0, 0,0, "R2 value", "R3 tainted state", "R9 no leak");
        // R5: trusted set dominates tainted others
        step(1,1, 1,1, 1,0, "R5 set value", "R5 set label", "R9 no leak");
        // R3: tainted set=0 with trusted clear=1 still taints
        step(0,0, 1,0, 0,1, "R2 value", "R3 set taint", "R9 no leak");
        // R4: tainted enable under trusted clear stays trusted
        step(1,1, 1,0, 0,0, "R2 clear", "R4 clear", "R9 no leak");
        // random traffic with periodic reset
        for (int i = 0; i < 3000; i++) begin
            bit re = 1'($urandom), rc, rs;
            bit ret = ($urandom % 4) == 0;
            bit rct = ($urandom % 5) == 0;
            bit rst_t = ($urandom % 6) == 0;
            rc = ($urandom % 5) == 0;
            rs = ($urandom % 7) == 0;
            if (i % 500 == 499) do_reset();
            step(re, ret, rc, rct, rs, rst_t, "R2 random", "R3 random", "R7 random");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule